// File: doc/BRIEF.md
# Signed Set-on-Condition Comparator

This unit compares two two's-complement operands under a three-bit condition selector. It returns a full-width result word whose least significant bit is 1 when the selected relation holds. Every other bit of the result is always 0. A processor datapath uses it to turn a comparison directly into a register value, without a separate flag register.

The unit is purely combinational. Internally, one shared signed less-than signal and one shared equality signal feed a small selector, and that selector derives all six relations. The less-than path does not depend on an overflowing subtraction. If the operand signs differ, the sign of the first operand decides the result. If the signs match, the remaining magnitude bits are compared as unsigned numbers. The unit also carries an overflow output, which stays low because a comparison never overflows.

The selector names its codes as an enumerated type: `SEL_LE`, `SEL_LT`, `SEL_GE`, `SEL_GT`, `SEL_EQ` and `SEL_NE`. The two codes left over fall to a default arm that yields zero. There are no states and no transitions.

Top module: `setcc_cmp`

## Requirements
- R1: Condition code 3'b000 selects "opa less than or equal to opb", signed.
- R2: Condition code 3'b001 selects "opa strictly less than opb", signed.
- R3: Condition code 3'b010 selects "opa greater than or equal to opb", signed.
- R4: Condition code 3'b011 selects "opa strictly greater than opb", signed.
- R5: Condition code 3'b100 selects "opa equal to opb".
- R6: Condition code 3'b101 selects "opa not equal to opb".
- R7: Condition codes 3'b110 and 3'b111 always give a result of all zeros.
- R8: A true condition gives a result of exactly 16'h0001, and a false one gives 16'h0000. Bits 15 down to 1 are never set.
- R9: The overflow output `ovf` is 0 for every input.
- R10: Ordering is correct across the whole signed range. For example, 16'h8000 is less than 16'h7FFF, and 16'hFFFF (-1) is less than 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand, two's complement |
| opb | input | 16 | Second operand, two's complement |
| cond | input | 3 | Condition selector |
| result | output | 16 | 16'h0001 when the condition holds, otherwise zero |
| ovf | output | 1 | Overflow indication, always 0 |

## Verification
Both outputs are due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The bench drives the operands and the condition code on the falling clock edge and compares both outputs with its behavioural model at the following rising edge, which gives the logic half a period to settle. Each operand pair is applied under all eight condition codes. The corner pairs cover the extremes of the signed range and operands with mixed signs.

// File: rtl/setcc_pkg.sv
package setcc_pkg;

    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_LE  = 3'b000,
        SEL_LT  = 3'b001,
        SEL_GE  = 3'b010,
        SEL_GT  = 3'b011,
        SEL_EQ  = 3'b100,
        SEL_NE  = 3'b101,
        SEL_RS6 = 3'b110,
        SEL_RS7 = 3'b111
    } sel_e;

endpackage

// File: rtl/setcc_slt.sv
// Signed less-than. When the signs differ, opa's sign bit gives the answer.
// When the signs match, the lower bits are compared as unsigned through a borrow.
module setcc_slt #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt
);
    localparam int unsigned MW = W - 1;

    logic          sign_diff;
    logic [MW:0]   mag_diff;
    logic          mag_borrow;

    always_comb begin
        sign_diff  = a[W-1] ^ b[W-1];
        mag_diff   = {1'b0, a[MW-1:0]} - {1'b0, b[MW-1:0]};
        mag_borrow = mag_diff[MW];
        lt         = sign_diff ? a[W-1] : mag_borrow;
    end
endmodule

// File: rtl/setcc_eq.sv
// Equality: per-bit match cells, then an AND reduction.
module setcc_eq #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] bit_match;

    for (genvar i = 0; i < W; i++) begin : g_match
        assign bit_match[i] = ~(a[i] ^ b[i]);
    end

    assign eq = &bit_match;
endmodule

// File: rtl/setcc_sel.sv
// Derives all six relations from one less-than and one equality signal.
module setcc_sel
    import setcc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             lt,
    input  logic             eq,
    output logic [W-1:0]     word
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        unique case (sel_e'(sel))
            SEL_LE:  hit = lt | eq;
            SEL_LT:  hit = lt;
            SEL_GE:  hit = ~lt;
            SEL_GT:  hit = ~(lt | eq);
            SEL_EQ:  hit = eq;
            SEL_NE:  hit = ~eq;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        word    = '0;
        word[0] = hit;
    end
endmodule

// File: rtl/setcc_cmp.sv
module setcc_cmp
    import setcc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [SEL_W-1:0] cond,
    output logic [W-1:0]     result,
    output logic             ovf
);
    logic lt_s;
    logic eq_s;

    setcc_slt #(.W(W)) u_slt (.a(opa), .b(opb), .lt(lt_s));
    setcc_eq  #(.W(W)) u_eq  (.a(opa), .b(opb), .eq(eq_s));
    setcc_sel #(.W(W)) u_sel (.sel(cond), .lt(lt_s), .eq(eq_s), .word(result));

    assign ovf = 1'b0;
endmodule

// File: rtl/setcc_cmp_chk.sv
module setcc_cmp_chk
    import setcc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [SEL_W-1:0] cond,
    input logic [W-1:0]     result,
    input logic             ovf
);
    always_comb begin
        if (!$isunknown({opa, opb, cond, result, ovf})) begin
            // R9
            no_overflow_chk: assert (ovf == 1'b0);
            // R8
            upper_zero_chk: assert (result[W-1:1] == '0);
            // R7
            spare_code_chk: assert (!(cond[2] & cond[1]) || result == '0);
            // R2
            lt_match_chk: assert (cond != 3'b001 ||
                                  result[0] == ($signed(opa) < $signed(opb)));
            // R5
            eq_match_chk: assert (cond != 3'b100 || result[0] == (opa == opb));
            // R4
            gt_match_chk: assert (cond != 3'b011 ||
                                  result[0] == ($signed(opa) > $signed(opb)));
        end
    end
endmodule

bind setcc_cmp setcc_cmp_chk #(.W(W)) u_chk (
    .opa(opa), .opb(opb), .cond(cond), .result(result), .ovf(ovf)
);

// File: tb/setcc_cmp_bench.sv
`timescale 1ns/1ps
module setcc_cmp_bench;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [2:0]    cond = 3'b100;
    logic [W-1:0]  result;
    logic          ovf;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    setcc_cmp #(.W(W)) u_setcc_cmp (
        .opa(opa), .opb(opb), .cond(cond), .result(result), .ovf(ovf)
    );

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [2:0] c);
        int sa, sb;
        bit t;
        sa = (a >= 16'h8000) ? int'(a) - 65536 : int'(a);
        sb = (b >= 16'h8000) ? int'(b) - 65536 : int'(b);
        case (c)
            3'd0: t = sa <= sb;
            3'd1: t = sa <  sb;
            3'd2: t = sa >= sb;
            3'd3: t = sa >  sb;
            3'd4: t = sa == sb;
            3'd5: t = sa != sb;
            default: t = 1'b0;
        endcase
        return t ? 16'h0001 : 16'h0000;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string extra);
        logic [W-1:0] exp_w;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            opa = a; opb = b; cond = 3'(c);
            exp_w = model(a, b, 3'(c));
            @(posedge clk);
            n_run++;
            if (result !== exp_w) begin
                n_fail++;
                $display("FAIL %s%s (R8) a=%h b=%h cond=%0d result=%h expected=%h",
                         req_of(3'(c)), extra, a, b, c, result, exp_w);
            end
            n_run++;
            if (ovf !== 1'b0) begin
                n_fail++;
                $display("FAIL R9 a=%h b=%h cond=%0d ovf=%b expected=0",
                         a, b, c, ovf);
            end
        end
    endtask

    initial begin
        // Quiescent state: zero operands, equality code -> 1 (R5)
        @(posedge clk);
        n_run++;
        if (result !== 16'h0001) begin
            n_fail++;
            $display("FAIL R5 initial result=%h expected=0001", result);
        end
        // Signed range corners (R10)
        apply(16'h8000, 16'h7FFF, " R10");
        apply(16'h7FFF, 16'h8000, " R10");
        apply(16'hFFFF, 16'h0000, " R10");
        apply(16'h0000, 16'hFFFF, " R10");
        apply(16'h8000, 16'h8000, " R10");
        apply(16'h7FFF, 16'h7FFF, " R10");
        apply(16'h8000, 16'h8001, " R10");
        apply(16'hFFFE, 16'hFFFF, " R10");
        apply(16'h0001, 16'h0002, "");
        apply(16'h1234, 16'h1234, "");
        apply(16'h00FF, 16'hFF00, " R10");
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ra = rng[15:0];
            rb = (i % 5 == 0) ? rng[15:0] : rng[31:16];
            apply(ra, rb, "");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule